// File: doc/BRIEF.md
# Addressable Bit Latch with One-of-N Demultiplex Mode

This block holds a small bank of output bits, by default eight, and updates them one at a time. A three-bit select chooses which bit a single data input lands in. Two active-low controls, a write enable and a clear, together choose one of four behaviours. The block can act as a bank of individually written flags, keep its contents unchanged, route the data bit to one output line while every other line sits low, or force every line low.

The block is a clock-synchronous version of such a latch. Writes take effect on the rising clock edge and appear on the outputs after that edge. The demultiplex and clear behaviours drive the outputs directly from the inputs within the same cycle. The clear control also empties the stored bits at once, without waiting for a clock edge. A synchronous active-high reset empties the storage at a clock edge. The caller must keep the select lines steady for the whole of any cycle in which the write enable is low.

Top module: `bitsel_latch`

## Requirements
- R1: While `rst` is high at a rising edge, every stored bit becomes 0 at that edge. The outputs do not change before that edge. With `clr_n`=1 and `wr_en_n`=1 after reset, `q` reads all zeros.
- R2: With `clr_n`=1 and `wr_en_n`=0 at a rising edge, stored bit number `sel` takes the value of `din`. `q` shows the stored bits, so the new value is visible from that edge onward.
- R3: In that same write mode, every stored bit other than number `sel` keeps its value across the edge.
- R4: With `clr_n`=1 and `wr_en_n`=1 (hold), no stored bit changes across an edge, whatever `din` and `sel` are.
- R5: With `clr_n`=0 and `wr_en_n`=0 (demultiplex), `q[sel]` equals `din` and every other bit of `q` is 0. This follows the inputs within the cycle, with no clock edge needed.
- R6: With `clr_n`=0 and `wr_en_n`=1 (clear), every bit of `q` is 0, whatever `din` and `sel` are.
- R7: A low level on `clr_n` empties the storage without a clock edge. In demultiplex and clear modes alike, after `clr_n` returns high, `q` reads all zeros until a write takes place.
- R8: `sel` is a plain unsigned binary index. `sel`=0 addresses `q[0]` and `sel`=7 addresses `q[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the storage |
| din | input | 1 | Data bit to write or to route |
| sel | input | SEL_W (3) | Binary index of the addressed bit |
| wr_en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear, asynchronous on storage |
| q | output | LANES (8) | Output bits |

## Verification
The checker tests on every cycle that clear mode gives all zeros and that demultiplex mode gives exactly one routed bit. It also tests that the addressed bit receives the data after a write and that no other bit rises during a write or a hold. It tests that the outputs read zero on the edge after `clr_n` is released. Only the bench scenarios can show the following: the exact bank contents after runs of writes, the binary order of the select lines, and that a clear pulse shorter than a clock period empties the storage between edges. The bench also shows a reset that arrives in the middle of a run, and each of the sixteen mode-to-mode transitions.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    localparam int unsigned LANES_DEFAULT = 8;

    // Mode code is {~clr_n, wr_en_n}
    typedef enum logic [1:0] {
        LM_WRITE = 2'b00,
        LM_HOLD  = 2'b01,
        LM_DEMUX = 2'b10,
        LM_CLEAR = 2'b11
    } lat_mode_e;

    typedef struct packed {
        lat_mode_e mode;
        logic      store_wr;   // storage takes din at the addressed bit
        logic      route;      // outputs follow the one-hot data path
        logic      blank;      // outputs forced low
    } mode_ctl_t;

    function automatic lat_mode_e mode_of(input logic clr_n, input logic en_n);
        return lat_mode_e'({~clr_n, en_n});
    endfunction

    function automatic int unsigned sel_width(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/bsl_mode_dec.sv
module bsl_mode_dec
    import bsl_pkg::*;
(
    input  logic      clr_n,
    input  logic      wr_en_n,
    output mode_ctl_t ctl
);
    always_comb begin
        ctl          = '0;
        ctl.mode     = mode_of(clr_n, wr_en_n);
        unique case (ctl.mode)
            LM_WRITE: ctl.store_wr = 1'b1;
            LM_HOLD:  ctl.store_wr = 1'b0;
            LM_DEMUX: ctl.route    = 1'b1;
            LM_CLEAR: ctl.blank    = 1'b1;
            default:  ctl.blank    = 1'b1;
        endcase
    end
endmodule

// File: rtl/bsl_sel_dec.sv
module bsl_sel_dec #(
    parameter int unsigned LANES = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LANES-1:0] line
);
    for (genvar i = 0; i < LANES; i++) begin : g_line
        assign line[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/bsl_store.sv
module bsl_store #(
    parameter int unsigned LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             wr,
    input  logic [LANES-1:0] line,
    input  logic             din,
    output logic [LANES-1:0] bits
);
    for (genvar i = 0; i < LANES; i++) begin : g_cell
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                bits[i] <= 1'b0;
            end else if (rst) begin
                bits[i] <= 1'b0;
            end else if (wr && line[i]) begin
                bits[i] <= din;
            end
        end
    end
endmodule

// File: rtl/bsl_out_mux.sv
module bsl_out_mux
    import bsl_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  mode_ctl_t        ctl,
    input  logic [LANES-1:0] bits,
    input  logic [LANES-1:0] line,
    input  logic             din,
    output logic [LANES-1:0] q
);
    always_comb begin
        if (ctl.blank) begin
            q = '0;
        end else if (ctl.route) begin
            q = line & {LANES{din}};
        end else begin
            q = bits;
        end
    end
endmodule

// File: rtl/bitsel_latch.sv
module bitsel_latch
    import bsl_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEFAULT,
    parameter int unsigned SEL_W = sel_width(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_en_n,
    input  logic             clr_n,
    output logic [LANES-1:0] q
);
    mode_ctl_t        ctl;
    logic [LANES-1:0] line;
    logic [LANES-1:0] bits;

    bsl_mode_dec u_mode (
        .clr_n   (clr_n),
        .wr_en_n (wr_en_n),
        .ctl     (ctl)
    );

    bsl_sel_dec #(.LANES(LANES), .SEL_W(SEL_W)) u_sel (
        .sel  (sel),
        .line (line)
    );

    bsl_store #(.LANES(LANES)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .wr    (ctl.store_wr),
        .line  (line),
        .din   (din),
        .bits  (bits)
    );

    bsl_out_mux #(.LANES(LANES)) u_out (
        .ctl  (ctl),
        .bits (bits),
        .line (line),
        .din  (din),
        .q    (q)
    );
endmodule

// File: rtl/bsl_chk.sv
module bsl_chk #(
    parameter int unsigned LANES = 8,
    parameter int unsigned SEL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic [SEL_W-1:0] sel,
    input logic             wr_en_n,
    input logic             clr_n,
    input logic [LANES-1:0] q
);
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && wr_en_n) |-> (q == '0));

    // R5
    demux_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !wr_en_n) |-> ((q[sel] == din) && ($countones(q) == (din ? 1 : 0))));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_en_n) |=> (!clr_n || (q[$past(sel)] == $past(din))));

    // R3
    write_others_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_en_n) |=> (!clr_n ||
            (((q & ~$past(q)) & ~(LANES'(1) << $past(sel))) == '0)));

    // R4
    hold_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && wr_en_n) |=> (!clr_n || ((q & ~$past(q)) == '0)));

    // R7
    release_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_n) |=> (!clr_n || (q == '0)));
endmodule

bind bitsel_latch bsl_chk #(.LANES(LANES), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .sel     (sel),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .q       (q)
);

// File: tb/bitsel_latch_test.sv
module bitsel_latch_test;
    typedef struct {
        logic [7:0] q;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;

    item_t      sb[$];
    logic [7:0] model = 8'h00;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    bitsel_latch uut (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, queue the expected q, advance the model
    task automatic apply(input logic c, input logic e, input logic [2:0] s,
                         input logic d, input logic r, input string req);
        item_t it;
        @(negedge clk);
        clr_n = c; wr_en_n = e; sel = s; din = d; rst = r;
        if (!c && !e)      it.q = 8'(d) << s;
        else if (!c)       it.q = 8'h00;
        else               it.q = model;
        it.req = (req != "") ? req : (!c ? (!e ? "R5" : "R6") : (!e ? "R2" : "R4"));
        sb.push_back(it);
        if (!c || r)       model = 8'h00;
        else if (!e)       model[s] = d;
    endtask

    function automatic logic [1:0] code(input int m);
        return {~m[1], m[0]};  // {clr_n, wr_en_n}
    endfunction

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(q, it.q, it.req);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: q=%02h expected completion", q);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] pat;
        repeat (3) @(posedge clk);
        // R1: reset empties storage
        apply(1, 1, 3'd0, 1'b0, 1'b0, "R1");
        apply(1, 1, 3'd5, 1'b1, 1'b0, "R1");

        // R8: bit 0 and bit 7 addressing
        apply(1, 0, 3'd0, 1'b1, 1'b0, "R2");
        apply(1, 1, 3'd0, 1'b0, 1'b0, "R8");   // expect 01
        apply(1, 0, 3'd7, 1'b1, 1'b0, "R2");
        apply(1, 1, 3'd7, 1'b0, 1'b0, "R8");   // expect 81

        // R2: fill a pattern at all addresses
        pat = 8'hA5;
        for (int i = 0; i < 8; i++) apply(1, 0, 3'(i), pat[i], 1'b0, "R2");
        apply(1, 1, 3'd2, 1'b1, 1'b0, "R8");   // expect A5

        // R3: overwrite one bit, others keep
        apply(1, 0, 3'd5, 1'b0, 1'b0, "R3");
        apply(1, 1, 3'd5, 1'b1, 1'b0, "R3");   // expect 85
        apply(1, 0, 3'd1, 1'b1, 1'b0, "R3");
        apply(1, 1, 3'd0, 1'b0, 1'b0, "R3");   // expect 87

        // R4: hold ignores sel and din
        for (int i = 0; i < 8; i++) apply(1, 1, 3'(i), i[0], 1'b0, "R4");

        // R5: demultiplex every address, both data values
        for (int i = 0; i < 16; i++) apply(0, 0, 3'(i % 8), i[3], 1'b0, "R5");
        apply(1, 1, 3'd3, 1'b1, 1'b0, "R7");   // storage emptied by demux

        // R6: clear mode ignores sel and din
        for (int i = 0; i < 8; i++) apply(1, 0, 3'(i), 1'b1, 1'b0, "R2");
        for (int i = 0; i < 16; i++) apply(0, 1, 3'(i % 8), i[3], 1'b0, "R6");
        apply(1, 1, 3'd6, 1'b1, 1'b0, "R7");   // storage emptied by clear

        // R7: short clear pulse between edges, no clock needed
        apply(1, 0, 3'd4, 1'b1, 1'b0, "R2");
        apply(1, 1, 3'd4, 1'b0, 1'b0, "R4");   // expect 10
        @(posedge clk);
        #2 clr_n = 1'b0;
        #1 check(q, 8'h00, "R7");
        #1 clr_n = 1'b1;
        #1 check(q, 8'h00, "R7");
        model = 8'h00;
        apply(1, 1, 3'd4, 1'b1, 1'b0, "R7");

        // Every mode-to-mode transition
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [1:0] ca = code(a);
                logic [1:0] cb = code(b);
                apply(1, 0, 3'((a + b) % 8), 1'b1, 1'b0, "R2");
                apply(ca[1], ca[0], 3'((a * 4 + b) % 8), 1'(a ^ b), 1'b0, "");
                apply(cb[1], cb[0], 3'((a * 3 + b + 1) % 8), 1'(b), 1'b0, "");
                apply(1, 1, 3'd0, 1'b0, 1'b0, "");
            end
        end

        // R1: reset mid-run is synchronous
        for (int i = 0; i < 4; i++) apply(1, 0, 3'(i * 2), 1'b1, 1'b0, "R2");
        apply(1, 1, 3'd0, 1'b0, 1'b1, "R1");   // still 55 before the edge
        apply(1, 1, 3'd0, 1'b0, 1'b0, "R1");   // 00 after the edge

        repeat (3) @(negedge clk);
        #4;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule